// File: doc/BRIEF.md
# Programmable Counter/Timer with Square-Wave Output

This block is a down-counter with a 16-bit preload. The CPU builds the preload one byte at a time through two write-only byte registers. Two commands control the block. The CPU issues each command as a read at a fixed address: one address starts the counter and the other stops it.

In timer mode the block runs without stopping and produces a square wave on `sq_out`. Each level of the wave lasts the preload value in clock cycles, so a full period lasts twice the preload. The ready flag sets once per full period. The stop command clears that flag and does not halt the timer. A new preload value only shapes the half-periods that begin after the write.

In counter mode the block counts down once from the preload to terminal count. At terminal count it raises the ready flag, then halts and holds until the next start command. A stop command issued in counter mode halts the count at once. After reset the block is idle, `sq_out` is low and the mode input defaults to timer operation. Nothing counts until a start command arrives.

Top module: `ct_timer`

## Requirements
- R1: After reset, `active`, `ready` and `sq_out` are 0, and they hold with no change until a start command is decoded.
- R2: A write with `wr_sel`=0 loads preload bits 7:0 from `wr_byte`, and a write with `wr_sel`=1 loads bits 15:8. A start command loads the combined 16-bit value.
- R3: In timer mode (`count_mode`=0), after a start, `sq_out` holds each level for exactly the preload value P in clock cycles (P ≥ 2), so the full period is 2·P.
- R4: A preload write made during a half-period leaves the length of that half-period unchanged. The next half-period uses the new value.
- R5: In timer mode, `ready` sets in the same cycle that `sq_out` falls from 1 to 0, which is once per full period.
- R6: In timer mode a stop command (read at address 0xF) clears `ready` on the next cycle. `active` stays 1 and `sq_out` keeps toggling on schedule.
- R7: A start command (read at address 0xE) ends any cycle in progress. On the next cycle `active`=1 and `sq_out`=0, and a fresh half-period of P cycles begins from the current preload.
- R8: In counter mode (`count_mode`=1), P cycles after the start edge `ready` becomes 1 and `active` becomes 0. The block then holds with `ready` at 1 until the next command.
- R9: In counter mode a stop command sets `active` to 0 and `ready` to 0 on the next cycle, and the count does not resume.
- R10: A read at any address other than 0xE or 0xF has no effect on `active`, `ready` or `sq_out`.
- R11: When a stop command lands in the same cycle as a ready-setting event, `ready` ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Preload byte write strobe |
| wr_sel | input | 1 | Byte lane: 0 = bits 7:0, 1 = bits 15:8 |
| wr_byte | input | 8 | Byte to write |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | 4 | Read address (0xE start, 0xF stop) |
| count_mode | input | 1 | 0 = timer mode, 1 = counter mode |
| ready | output | 1 | Counter-ready status flag |
| sq_out | output | 1 | Square-wave output |
| active | output | 1 | 1 while the counter is running |

## Verification
The in-line assertions check the single-step rules on every cycle:
- the state right after a start;
- that a timer-mode stop leaves the block running;
- the halt at terminal count in counter mode;
- `ready` setting together with the falling edge of `sq_out`;
- the clearing of `ready` by stop;
- the frozen state while idle.

Some properties span many cycles and only the bench scenarios show them. These are the exact half-period length, the delayed effect of a mid-period preload write, the absence of any effect from reads at other addresses, and the priority of a ready-setting event over a stop that lands in the same cycle.

// File: rtl/ct_pkg.sv
package ct_pkg;

    typedef enum logic {
        MODE_TIMER   = 1'b0,
        MODE_COUNTER = 1'b1
    } ct_mode_e;

    typedef struct packed {
        logic start;
        logic stop;
    } ct_cmd_t;

    localparam int CT_BYTE_W = 8;

    function automatic logic ct_at_terminal(input logic [15:0] value);
        return (value <= 16'd1);
    endfunction

endpackage

// File: rtl/ct_cmd_decode.sv
module ct_cmd_decode
    import ct_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int START_ADDR = 14,
    parameter int STOP_ADDR  = 15
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output ct_cmd_t           cmd
);

    always_comb begin
        cmd.start = rd_en && (rd_addr == ADDR_W'(START_ADDR));
        cmd.stop  = rd_en && (rd_addr == ADDR_W'(STOP_ADDR));
    end

endmodule

// File: rtl/ct_preload.sv
module ct_preload
    import ct_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int NBYTES = WIDTH / CT_BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CT_BYTE_W-1:0] wr_byte,
    output logic [WIDTH-1:0]     value
);

    logic [CT_BYTE_W-1:0] lane_q [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '1;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                lane_q[g] <= wr_byte;
            end
        end
        assign value[g*CT_BYTE_W +: CT_BYTE_W] = lane_q[g];
    end

endmodule

// File: rtl/ct_core.sv
module ct_core
    import ct_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ct_mode_e         mode,
    input  ct_cmd_t          cmd,
    input  logic [WIDTH-1:0] preload,
    output logic             ready,
    output logic             sq_out,
    output logic             active
);

    logic [WIDTH-1:0] cnt_q;
    logic             act_q;
    logic             sq_q;
    logic             rdy_q;
    logic             tick;
    logic             term;
    logic             set_evt;

    always_comb begin
        tick    = act_q && !cmd.start && !(cmd.stop && mode == MODE_COUNTER);
        term    = ct_at_terminal(16'(cnt_q));
        set_evt = tick && term && (mode == MODE_COUNTER || sq_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
            sq_q  <= 1'b0;
        end else if (cmd.start) begin
            cnt_q <= preload;
            act_q <= 1'b1;
            sq_q  <= 1'b0;
        end else if (cmd.stop && mode == MODE_COUNTER) begin
            act_q <= 1'b0;
        end else if (tick) begin
            if (term) begin
                if (mode == MODE_TIMER) begin
                    cnt_q <= preload;
                    sq_q  <= ~sq_q;
                end else begin
                    cnt_q <= '0;
                    act_q <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= 1'b0;
        end else if (set_evt) begin
            rdy_q <= 1'b1;
        end else if (cmd.stop) begin
            rdy_q <= 1'b0;
        end
    end

    assign ready  = rdy_q;
    assign sq_out = sq_q;
    assign active = act_q;

    p_start_restart_r7: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> (act_q && !sq_q && cnt_q == $past(preload)));

    p_timer_keeps_running_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.stop && mode == MODE_TIMER && act_q) |=> act_q);

    p_terminal_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_COUNTER && tick && term) |=> (rdy_q && !act_q && cnt_q == '0));

    p_ready_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TIMER && tick && term && sq_q) |=> (rdy_q && !sq_q));

    p_stop_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd.stop && !set_evt) |=> !rdy_q);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!act_q && !cmd.start) |=> ($stable(sq_q) && $stable(cnt_q) && !act_q));

endmodule

// File: rtl/ct_timer.sv
module ct_timer
    import ct_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int ADDR_W     = 4,
    parameter int START_ADDR = 14,
    parameter int STOP_ADDR  = 15,
    localparam int NBYTES = WIDTH / CT_BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [CT_BYTE_W-1:0] wr_byte,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic                 count_mode,
    output logic                 ready,
    output logic                 sq_out,
    output logic                 active
);

    ct_cmd_t          cmd;
    logic [WIDTH-1:0] preload;
    ct_mode_e         mode;

    assign mode = ct_mode_e'(count_mode);

    ct_cmd_decode #(
        .ADDR_W    (ADDR_W),
        .START_ADDR(START_ADDR),
        .STOP_ADDR (STOP_ADDR)
    ) i_decode (
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .cmd    (cmd)
    );

    ct_preload #(.WIDTH(WIDTH)) i_preload (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_byte(wr_byte),
        .value  (preload)
    );

    ct_core #(.WIDTH(WIDTH)) i_core (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .cmd    (cmd),
        .preload(preload),
        .ready  (ready),
        .sq_out (sq_out),
        .active (active)
    );

endmodule

// File: tb/test_ct_timer.sv
module test_ct_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [0:0] wr_sel = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = 4'h0;
    logic       count_mode = 1'b0;
    logic       ready;
    logic       sq_out;
    logic       active;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    int m_pre = 16'hFFFF;
    int m_cnt = 0;
    int m_act = 0;
    int m_sq = 0;
    int m_rdy = 0;

    always #10 clk = ~clk;

    ct_timer i_ct_timer (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_byte   (wr_byte),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .count_mode(count_mode),
        .ready     (ready),
        .sq_out    (sq_out),
        .active    (active)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        int  old_pre;
        bit  go, halt, fire, counting;
        old_pre = m_pre;
        go   = rd_en && rd_addr == 4'hE;
        halt = rd_en && rd_addr == 4'hF;
        fire = 0;
        if (rst) begin
            m_pre = 16'hFFFF; m_cnt = 0; m_act = 0; m_sq = 0; m_rdy = 0;
        end else begin
            counting = m_act != 0 && !go && !(halt && count_mode);
            if (go) begin
                m_cnt = old_pre; m_act = 1; m_sq = 0;
            end else if (halt && count_mode) begin
                m_act = 0;
            end else if (counting) begin
                if (m_cnt <= 1) begin
                    if (!count_mode) begin
                        if (m_sq == 1) fire = 1;
                        m_sq = 1 - m_sq;
                        m_cnt = old_pre;
                    end else begin
                        fire = 1; m_act = 0; m_cnt = 0;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (fire) m_rdy = 1;
            else if (halt) m_rdy = 0;
            if (wr_en) begin
                if (wr_sel == 1'b1) m_pre = (m_pre & 16'h00FF) | (int'(wr_byte) << 8);
                else                m_pre = (m_pre & 16'hFF00) | int'(wr_byte);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (ready !== m_rdy[0] || sq_out !== m_sq[0] || active !== m_act[0]) begin
                bad++;
                $display("FAIL %s cycle compare: actual rdy=%b sq=%b act=%b expected rdy=%0d sq=%0d act=%0d",
                         tag, ready, sq_out, active, m_rdy, m_sq, m_act);
            end
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] b);
        wr_en = 1'b1; wr_sel = sel; wr_byte = b;
        idle(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        rd_en = 1'b1; rd_addr = a;
        idle(1);
        rd_en = 1'b0;
    endtask

    // cycles until sq_out reaches the given level
    task automatic level_wait(input logic lvl, output int n);
        n = 0;
        while (sq_out !== lvl && n < 1000) begin
            idle(1);
            n++;
        end
    endtask

    initial begin
        int n;
        idle(3);
        rst = 1'b0;
        tag = "R1";
        idle(1);
        check("R1 active after reset", active, 0);
        check("R1 ready after reset", ready, 0);
        check("R1 sq_out after reset", sq_out, 0);
        idle(5);
        check("R1 idle sq_out", sq_out, 0);

        tag = "R2";
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h03);
        tag = "R7";
        rd(4'hE);
        check("R7 active after start", active, 1);
        check("R7 sq_out low after start", sq_out, 0);
        tag = "R3";
        level_wait(1'b1, n);
        check("R3 R2 first low half length", n, 3);
        level_wait(1'b0, n);
        check("R3 high half length", n, 3);
        check("R5 ready on fall", ready, 1);

        tag = "R6";
        rd(4'hF);
        check("R6 ready cleared by stop", ready, 0);
        check("R6 still active", active, 1);
        level_wait(1'b1, n);
        check("R6 toggling continues", n, 2);

        tag = "R4";
        level_wait(1'b0, n);
        wr(1'b0, 8'h05);
        level_wait(1'b1, n);
        check("R4 current half unchanged", n, 2);
        level_wait(1'b0, n);
        check("R4 next half uses new value", n, 5);

        tag = "R10";
        check("R10 ready before stray reads", ready, 1);
        rd(4'h3);
        rd(4'hD);
        check("R10 ready after stray reads", ready, 1);
        check("R10 active after stray reads", active, 1);

        tag = "R11";
        rd(4'hF);
        n = 0;
        while (!(m_act == 1 && m_cnt == 1 && m_sq == 1) && n < 100) begin
            idle(1);
            n++;
        end
        rd(4'hF);
        check("R11 set wins over stop", ready, 1);

        tag = "R7";
        idle(2);
        rd(4'hE);
        check("R7 restart sq low", sq_out, 0);
        level_wait(1'b1, n);
        check("R7 restarted half length", n, 5);

        tag = "R8";
        count_mode = 1'b1;
        rd(4'hF);
        wr(1'b0, 8'h04);
        rd(4'hE);
        idle(3);
        check("R8 counting active", active, 1);
        check("R8 ready not yet", ready, 0);
        idle(1);
        check("R8 ready at terminal", ready, 1);
        check("R8 halted at terminal", active, 0);
        idle(10);
        check("R8 holds ready", ready, 1);
        check("R8 holds halted", active, 0);

        tag = "R9";
        rd(4'hE);
        idle(1);
        rd(4'hF);
        check("R9 stop halts", active, 0);
        check("R9 stop clears ready", ready, 0);
        idle(6);
        check("R9 stays halted", active, 0);
        check("R9 ready stays clear", ready, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule